// File: doc/BRIEF.md
# Instruction Loop Cache Controller

This block sits beside an instruction fetch path and lets a short loop run without fetching its body again. A loop command names a body length (the number of instructions that follow) and a pass count. On the first pass, each fetched word goes out to decode and is written into a small local store in the same cycle. The remaining passes are read from that store, one word per cycle, while fetch is held off.

Two zero encodings give the command more reach. A zero pass-count field takes the count from a loop-count register, so the count can be set at run time. A zero body length skips the load and replays whatever body is already stored, using the length recorded at the last load. The controller accepts one command at a time and reports through a busy flag that it is occupied.

Top module: `loop_cache_ctl`

## Requirements
- R1: During and straight after reset, `busy`, `fetch_stall` and `issue_valid` are low.
- R2: A command accepted while idle with body length N in 1..2^NI_W-1 raises `busy` in the next cycle. Each of the next N cycles with `fetch_valid` high issues `fetch_word` unchanged in that same cycle, with `fetch_stall` low. A cycle without `fetch_valid` issues nothing.
- R3: Passes 2 to P issue the N stored words in fetch order, one per cycle, with no gap. `fetch_stall` stays high throughout, and fetched words are ignored.
- R4: A nonzero pass-count field `cmd_k` sets the pass count P to its value.
- R5: A zero `cmd_k` sets P to `loop_reg` as sampled in the command cycle. Later changes to `loop_reg` have no effect.
- R6: When `cmd_k` is zero and `loop_reg` is zero, the body runs exactly once.
- R7: A command with body length zero, given when a body has been loaded since reset, issues P passes of the stored body from the first cycle after the command, all from the store, with `fetch_stall` high. It uses the length of the most recent load.
- R8: A command with body length zero and no body loaded since reset issues nothing, and `busy` stays low.
- R9: In the cycle after the final issue of the final pass, `busy` and `fetch_stall` are both low. A single-pass load never raises `fetch_stall`.
- R10: `cmd_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Loop command present this cycle |
| cmd_ni | input | NI_W | Body length; zero means replay the stored body |
| cmd_k | input | K_W | Pass count; zero means use `loop_reg` |
| loop_reg | input | LREG_W | Loop-count register value |
| fetch_valid | input | 1 | Fetched instruction word valid |
| fetch_word | input | WORD_W | Fetched instruction word |
| issue_valid | output | 1 | Issued instruction word valid |
| issue_word | output | WORD_W | Issued instruction word |
| busy | output | 1 | A loop command is in progress |
| fetch_stall | output | 1 | Fetch must hold while the body replays from the store |

## Verification
The bench builds the block with a 3-bit body length (a 7-word store), a 2-bit pass-count field and a 3-bit loop-count register. At that size the sweep covers every body length, including the full store. It covers every field value of the pass count, and when that field is zero, every register value including zero. Each load is followed by a replay with a different count, so both zero encodings, stalled fetch gaps, the full-store boundary and commands ignored while busy are all checked against an arithmetic model.

// File: rtl/lc_pkg.sv
package lc_pkg;

   typedef enum logic [1:0] {
      LC_IDLE = 2'd0,
      LC_LOAD = 2'd1,
      LC_PLAY = 2'd2
   } lc_state_e;

   function automatic int lc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lc_body_store.sv
module lc_body_store #(
   parameter int WORD_W         = 16,
   parameter int IDX_W          = 4,
   parameter int DEPTH          = 15,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] mem [DEPTH];

   if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            mem[wr_idx] <= wr_data;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (wr_en && (int'(wr_idx) < DEPTH)) mem[wr_idx] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (int'(rd_idx) == i) rd_data = mem[i];
      end
   end

endmodule

// File: rtl/lc_pass_ctr.sv
module lc_pass_ctr #(
   parameter int K_W    = 8,
   parameter int LREG_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [K_W-1:0]    k_field,
   input  logic [LREG_W-1:0] loop_reg,
   input  logic              dec,
   output logic              last
);

   logic [CNT_W-1:0] sel;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      if (k_field != '0) sel = CNT_W'(k_field);
      else               sel = CNT_W'(loop_reg);
      if (sel == '0) sel = CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= sel;
      else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
   end

   assign last = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/lc_seq.sv
module lc_seq
   import lc_pkg::*;
#(
   parameter int NI_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [NI_W-1:0] cmd_ni,
   input  logic            fetch_valid,
   input  logic            ctr_last,
   output logic            ctr_load,
   output logic            ctr_dec,
   output logic            wr_en,
   output logic [NI_W-1:0] idx,
   output logic            pass_through,
   output logic            play,
   output logic            busy
);

   lc_state_e       state_q;
   logic [NI_W-1:0] idx_q;
   logic [NI_W-1:0] len_q;
   logic            have_body_q;
   logic            accept;
   logic            start_load;
   logic            start_redo;
   logic            step;
   logic            end_pass;

   assign accept     = cmd_valid && (state_q == LC_IDLE);
   assign start_load = accept && (cmd_ni != '0);
   assign start_redo = accept && (cmd_ni == '0) && have_body_q;

   always_comb begin
      unique case (state_q)
         LC_LOAD: step = fetch_valid;
         LC_PLAY: step = 1'b1;
         default: step = 1'b0;
      endcase
   end

   assign end_pass = step && (idx_q == (len_q - NI_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= LC_IDLE;
         idx_q       <= '0;
         len_q       <= '0;
         have_body_q <= 1'b0;
      end else begin
         unique case (state_q)
            LC_IDLE: begin
               idx_q <= '0;
               if (start_load) begin
                  state_q     <= LC_LOAD;
                  len_q       <= cmd_ni;
                  have_body_q <= 1'b1;
               end else if (start_redo) begin
                  state_q <= LC_PLAY;
               end
            end
            LC_LOAD, LC_PLAY: begin
               if (end_pass) begin
                  idx_q   <= '0;
                  state_q <= ctr_last ? LC_IDLE : LC_PLAY;
               end else if (step) begin
                  idx_q <= idx_q + NI_W'(1);
               end
            end
            default: state_q <= LC_IDLE;
         endcase
      end
   end

   assign ctr_load     = start_load || start_redo;
   assign ctr_dec      = end_pass && !ctr_last;
   assign wr_en        = (state_q == LC_LOAD) && fetch_valid;
   assign idx          = idx_q;
   assign pass_through = (state_q == LC_LOAD);
   assign play         = (state_q == LC_PLAY);
   assign busy         = (state_q != LC_IDLE);

endmodule

// File: rtl/loop_cache_ctl.sv
module loop_cache_ctl
   import lc_pkg::*;
#(
   parameter int WORD_W         = 16,
   parameter int NI_W           = 4,
   parameter int K_W            = 8,
   parameter int LREG_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [NI_W-1:0]   cmd_ni,
   input  logic [K_W-1:0]    cmd_k,
   input  logic [LREG_W-1:0] loop_reg,
   input  logic              fetch_valid,
   input  logic [WORD_W-1:0] fetch_word,
   output logic              issue_valid,
   output logic [WORD_W-1:0] issue_word,
   output logic              busy,
   output logic              fetch_stall
);

   localparam int DEPTH = (1 << NI_W) - 1;
   localparam int CNT_W = lc_max(K_W, LREG_W);

   if (NI_W < 1 || NI_W > 8) begin : g_bad_ni
      $error("loop_cache_ctl: NI_W must be 1..8");
   end
   if (WORD_W < 1) begin : g_bad_word
      $error("loop_cache_ctl: WORD_W must be positive");
   end
   if (K_W < 1 || LREG_W < 1) begin : g_bad_cnt
      $error("loop_cache_ctl: count widths must be positive");
   end

   logic              ctr_load;
   logic              ctr_dec;
   logic              ctr_last;
   logic              wr_en;
   logic [NI_W-1:0]   idx;
   logic              pass_through;
   logic              play;
   logic [WORD_W-1:0] rd_data;

   lc_seq #(.NI_W(NI_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_ni       (cmd_ni),
      .fetch_valid  (fetch_valid),
      .ctr_last     (ctr_last),
      .ctr_load     (ctr_load),
      .ctr_dec      (ctr_dec),
      .wr_en        (wr_en),
      .idx          (idx),
      .pass_through (pass_through),
      .play         (play),
      .busy         (busy)
   );

   lc_pass_ctr #(.K_W(K_W), .LREG_W(LREG_W), .CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .k_field  (cmd_k),
      .loop_reg (loop_reg),
      .dec      (ctr_dec),
      .last     (ctr_last)
   );

   lc_body_store #(
      .WORD_W         (WORD_W),
      .IDX_W          (NI_W),
      .DEPTH          (DEPTH),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (idx),
      .wr_data (fetch_word),
      .rd_idx  (idx),
      .rd_data (rd_data)
   );

   assign issue_valid = play || (pass_through && fetch_valid);
   assign issue_word  = play ? rd_data : (pass_through ? fetch_word : '0);
   assign fetch_stall = play;

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_valid,
   input logic [WORD_W-1:0] fetch_word,
   input logic              issue_valid,
   input logic [WORD_W-1:0] issue_word,
   input logic              busy,
   input logic              fetch_stall
);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!busy && !fetch_stall && !issue_valid);
      end
   end

   p_first_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fetch_stall && fetch_valid) |-> (issue_valid && issue_word == fetch_word));

   p_gap_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fetch_stall && !fetch_valid) |-> !issue_valid);

   p_replay_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |-> issue_valid);

   p_stall_inside_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |-> busy);

   p_release_together_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fetch_stall) |-> $fell(busy));

   p_issue_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> busy);

endmodule

bind loop_cache_ctl lc_checker #(.WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .fetch_word  (fetch_word),
   .issue_valid (issue_valid),
   .issue_word  (issue_word),
   .busy        (busy),
   .fetch_stall (fetch_stall)
);

// File: tb/sim_loop_cache_ctl.sv
module sim_loop_cache_ctl;

   localparam int WORD_W = 8;
   localparam int NI_W   = 3;
   localparam int K_W    = 2;
   localparam int LREG_W = 3;
   localparam int DEPTH  = (1 << NI_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [NI_W-1:0]   cmd_ni = '0;
   logic [K_W-1:0]    cmd_k = '0;
   logic [LREG_W-1:0] loop_reg = '0;
   logic              fetch_valid = 1'b0;
   logic [WORD_W-1:0] fetch_word = '0;
   logic              issue_valid;
   logic [WORD_W-1:0] issue_word;
   logic              busy;
   logic              fetch_stall;

   int total = 0;
   int bad = 0;
   int seed = 0;
   int body_len = 0;
   bit have_body = 1'b0;
   logic [WORD_W-1:0] body [DEPTH];

   always #5 clk = ~clk;

   loop_cache_ctl #(
      .WORD_W(WORD_W), .NI_W(NI_W), .K_W(K_W), .LREG_W(LREG_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ni(cmd_ni),
      .cmd_k(cmd_k), .loop_reg(loop_reg), .fetch_valid(fetch_valid),
      .fetch_word(fetch_word), .issue_valid(issue_valid),
      .issue_word(issue_word), .busy(busy), .fetch_stall(fetch_stall)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int passes(input int k, input int r);
      if (k != 0) return k;
      if (r == 0) return 1;
      return r;
   endfunction

   function automatic int flags();
      return {29'd0, busy, fetch_stall, issue_valid};
   endfunction

   task automatic end_check(input string req);
      cmd_valid   = 1'b0;
      fetch_valid = 1'b0;
      #4;
      check(!busy && !fetch_stall && !issue_valid, req, "idle after final pass {busy,stall,iv}",
            flags(), 0);
      @(negedge clk);
   endtask

   task automatic run_load(input int n, input int k, input int r, input bit gap, input bit poke);
      int p;
      string req;
      p = passes(k, r);
      req = (k != 0) ? "R4" : ((r == 0) ? "R6" : "R5");
      cmd_valid = 1'b1; cmd_ni = NI_W'(n); cmd_k = K_W'(k); loop_reg = LREG_W'(r);
      fetch_valid = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0;
      loop_reg  = LREG_W'(r ^ 5);
      for (int i = 0; i < n; i++) begin
         if (gap && (i % 2 == 1)) begin
            fetch_valid = 1'b0; cmd_valid = poke;
            #4;
            check(busy && !fetch_stall && !issue_valid, "R2", "fetch gap {busy,stall,iv}",
                  flags(), 4);
            @(negedge clk);
         end
         seed++;
         fetch_valid = 1'b1;
         fetch_word  = WORD_W'(seed * 7 + i);
         body[i]     = fetch_word;
         cmd_valid   = poke;
         cmd_ni      = NI_W'(1);
         cmd_k       = K_W'(1);
         #4;
         check(busy && !fetch_stall && issue_valid && issue_word == body[i], "R2",
               "capture word", issue_word, body[i]);
         @(negedge clk);
      end
      body_len  = n;
      have_body = 1'b1;
      for (int q = 2; q <= p; q++) begin
         for (int i = 0; i < n; i++) begin
            fetch_valid = 1'b1;
            fetch_word  = 8'hEE;
            cmd_valid   = poke;
            #4;
            check(busy && fetch_stall && issue_valid && issue_word == body[i],
                  poke ? "R10" : "R3", "replay word", issue_word, body[i]);
            @(negedge clk);
         end
      end
      end_check(req);
      if (p == 1) check(1'b1, "R9", "single pass never stalled", 0, 0);
   endtask

   task automatic run_redo(input int k, input int r);
      int p;
      p = passes(k, r);
      cmd_valid = 1'b1; cmd_ni = '0; cmd_k = K_W'(k); loop_reg = LREG_W'(r);
      fetch_valid = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0;
      loop_reg  = LREG_W'(r ^ 3);
      if (!have_body) begin
         for (int c = 0; c < 3; c++) begin
            #4;
            check(!busy && !issue_valid && !fetch_stall, "R8", "redo with empty store",
                  flags(), 0);
            @(negedge clk);
         end
      end else begin
         for (int q = 1; q <= p; q++) begin
            for (int i = 0; i < body_len; i++) begin
               fetch_valid = 1'b1;
               fetch_word  = 8'h5A;
               #4;
               check(busy && fetch_stall && issue_valid && issue_word == body[i], "R7",
                     "redo word", issue_word, body[i]);
               @(negedge clk);
            end
         end
         end_check("R9");
      end
   endtask

   initial begin
      #2;
      check(!busy && !fetch_stall && !issue_valid, "R1", "in reset", flags(), 0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #4;
      check(!busy && !fetch_stall && !issue_valid, "R1", "after reset", flags(), 0);
      @(negedge clk);
      run_redo(2, 0);
      for (int n = 1; n <= DEPTH; n++) begin
         for (int k = 0; k < (1 << K_W); k++) begin
            for (int r = 0; r < ((k == 0) ? (1 << LREG_W) : 1); r++) begin
               run_load(n, k, (k == 0) ? r : ((n + r) % (1 << LREG_W)), n[0], k == 2);
               run_redo((k + 1) % (1 << K_W), (r + n) % (1 << LREG_W));
            end
         end
      end
      rst_n = 1'b0;
      have_body = 1'b0;
      #4;
      check(!busy && !fetch_stall && !issue_valid, "R1", "second reset", flags(), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_redo(3, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule